// File: doc/BRIEF.md
# Register Access Permission Gate

This block stands in front of a bank of eight timekeeping registers and decides, access by access, whether a bus write or a bus read may reach them. Two permission masks of eight bits each hold the decision: one mask governs writes, the other governs reads, and bit i of each mask covers target register i. A permission bit can be revoked by software but never granted back. Only the system reset re-arms it. The software reset and the backup-domain power-on reset return the target registers to zero and leave both masks as they are.

The bus is a plain 32-bit register port with a 12-bit byte address, a write strobe, a read strobe and a read data bus. Read data appears in the cycle after the read strobe and is zero in every other cycle. The read path is a small state machine. State `RS_IDLE` means no read was taken on the previous edge. `RS_TARGET` means a permitted target read. `RS_PERM` means a read of a permission mask. `RS_EMPTY` means a read that was blocked or hit no register. On each edge the machine moves to the state given by the current access: `go_target` (a read of a permitted target), `go_perm` (a read of either mask), `go_empty` (a blocked or unmapped read) or `go_idle` (no read strobe). Any state can move to any other.

The target registers are simple storage. The block models no timekeeping behaviour, no clocking and no interrupts.

Top module: `regaccess_guard`

## Requirements
- R1: After system reset, the write mask (offset 0x800) and the read mask (offset 0x804) both read 0x000000FF, and every target register reads 0.
- R2: Bits 31..8 of both mask registers always read zero, and writing ones to them changes nothing.
- R3: Target register i sits at byte offset 4*i for i = 0..7. The index order is seconds, prescaler, alarm, compensation, control, status, lock, interrupt enable. A write to a target whose write-mask bit i is 1 stores the data, and a read returns it on bus_rdata in the next cycle.
- R4: A write to target i while write-mask bit i is 0 is discarded, and the stored value is unchanged.
- R5: A read of target i while read-mask bit i is 0 returns 0x00000000 in the next cycle and raises no error.
- R6: Writing a mask register clears every bit i where bus_wdata[i] is 0. Bits written with 1 keep their value, so a cleared bit stays cleared.
- R7: A software reset pulse or a backup-domain reset pulse sets all target registers to zero and leaves both masks unchanged.
- R8: The system reset sets both masks back to 0xFF, which restores write and read access to every target.
- R9: bus_rdata is zero in any cycle that does not follow a read strobe. Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.
- R10: Both mask registers can be read at all times, whatever their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset pulse, active high, synchronous |
| bkp_por | input | 1 | Backup-domain power-on reset pulse, active high, synchronous |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that a mask write never coincides with a software or backup-domain reset pulse, because the check that the masks stay stable is only meaningful when no write competes with it. The bench drives every access as a single-cycle strobe from a task. It drives the reset pulses from separate steps with the bus idle, so the stimulus stays inside these assumptions.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int NREG   = 8;

    localparam logic [ADDR_W-1:0] WMASK_OFS = 12'h800;
    localparam logic [ADDR_W-1:0] RMASK_OFS = 12'h804;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_TARGET,
        ACC_WMASK,
        ACC_RMASK
    } acc_kind_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_TARGET,
        RS_PERM,
        RS_EMPTY
    } rd_state_t;
endpackage

// File: rtl/guard_decode.sv
module guard_decode
    import guard_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int NREG_P   = NREG,
    localparam int IDX_W   = $clog2(NREG_P),
    localparam int SPAN    = NREG_P * 4
) (
    input  logic [ADDR_W_P-1:0] addr,
    output acc_kind_t           kind,
    output logic [IDX_W-1:0]    idx
);
    assign idx = addr[IDX_W+1:2];

    always_comb begin
        if (addr == WMASK_OFS)
            kind = ACC_WMASK;
        else if (addr == RMASK_OFS)
            kind = ACC_RMASK;
        else if ((addr[1:0] == 2'b00) && (int'(addr) < SPAN))
            kind = ACC_TARGET;
        else
            kind = ACC_NONE;
    end
endmodule

// File: rtl/guard_mask.sv
module guard_mask #(
    parameter int NREG_P = 8
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              clr_en,
    input  logic [NREG_P-1:0] keep,
    output logic [NREG_P-1:0] mask
);
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)
            mask <= '1;
        else if (clr_en)
            mask <= mask & keep;
    end
endmodule

// File: rtl/guard_store.sv
module guard_store #(
    parameter int DATA_W_P = 32,
    parameter int NREG_P   = 8,
    localparam int IDX_W   = $clog2(NREG_P)
) (
    input  logic                       clk,
    input  logic                       sys_rst_n,
    input  logic                       dom_clr,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W_P-1:0]        wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W_P-1:0]        rd_data,
    output logic [NREG_P*DATA_W_P-1:0] flat
);
    for (genvar g = 0; g < NREG_P; g++) begin : g_reg
        logic [DATA_W_P-1:0] val;
        always_ff @(posedge clk or negedge sys_rst_n) begin
            if (!sys_rst_n)
                val <= '0;
            else if (dom_clr)
                val <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                val <= wr_data;
        end
        assign flat[g*DATA_W_P +: DATA_W_P] = val;
    end

    assign rd_data = flat[rd_idx*DATA_W_P +: DATA_W_P];
endmodule

// File: rtl/regaccess_guard.sv
module regaccess_guard
    import guard_pkg::*;
#(
    parameter int DATA_W_P = DATA_W,
    parameter int ADDR_W_P = ADDR_W,
    parameter int NREG_P   = NREG,
    localparam int IDX_W   = $clog2(NREG_P)
) (
    input  logic                clk,
    input  logic                sys_rst_n,
    input  logic                sw_rst,
    input  logic                bkp_por,
    input  logic [ADDR_W_P-1:0] bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W_P-1:0] bus_wdata,
    output logic [DATA_W_P-1:0] bus_rdata
);
    acc_kind_t                    kind;
    logic [IDX_W-1:0]             idx;
    logic [NREG_P-1:0]            wmask;
    logic [NREG_P-1:0]            rmask;
    logic [DATA_W_P-1:0]          tgt_rdata;
    logic [NREG_P*DATA_W_P-1:0]   store_flat;
    logic                         tgt_we;
    logic                         unused_hi;

    rd_state_t                    state_q, state_d;
    logic [DATA_W_P-1:0]          snap_q, snap_d;

    assign unused_hi = ^bus_wdata[DATA_W_P-1:NREG_P];

    guard_decode #(.ADDR_W_P(ADDR_W_P), .NREG_P(NREG_P)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    guard_mask #(.NREG_P(NREG_P)) u_wmask (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .clr_en    (bus_wr && (kind == ACC_WMASK)),
        .keep      (bus_wdata[NREG_P-1:0]),
        .mask      (wmask)
    );

    guard_mask #(.NREG_P(NREG_P)) u_rmask (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .clr_en    (bus_wr && (kind == ACC_RMASK)),
        .keep      (bus_wdata[NREG_P-1:0]),
        .mask      (rmask)
    );

    assign tgt_we = bus_wr && (kind == ACC_TARGET) && wmask[idx];

    guard_store #(.DATA_W_P(DATA_W_P), .NREG_P(NREG_P)) u_store (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .dom_clr   (sw_rst || bkp_por),
        .wr_en     (tgt_we),
        .wr_idx    (idx),
        .wr_data   (bus_wdata),
        .rd_idx    (idx),
        .rd_data   (tgt_rdata),
        .flat      (store_flat)
    );

    // Next-state selection: go_target, go_perm, go_empty, go_idle
    always_comb begin
        state_d = RS_IDLE;
        snap_d  = '0;
        if (bus_rd) begin
            unique case (kind)
                ACC_TARGET: begin
                    if (rmask[idx]) begin
                        state_d = RS_TARGET;
                        snap_d  = tgt_rdata;
                    end else begin
                        state_d = RS_EMPTY;
                    end
                end
                ACC_WMASK: begin
                    state_d = RS_PERM;
                    snap_d  = {{(DATA_W_P-NREG_P){1'b0}}, wmask};
                end
                ACC_RMASK: begin
                    state_d = RS_PERM;
                    snap_d  = {{(DATA_W_P-NREG_P){1'b0}}, rmask};
                end
                ACC_NONE: state_d = RS_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state_q <= RS_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            snap_q  <= snap_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RS_TARGET, RS_PERM: bus_rdata = snap_q;
            RS_IDLE, RS_EMPTY:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/regaccess_guard_checker.sv
module regaccess_guard_checker #(
    parameter int DATA_W_P = 32,
    parameter int ADDR_W_P = 12,
    parameter int NREG_P   = 8,
    localparam int IDX_W   = $clog2(NREG_P)
) (
    input logic                       clk,
    input logic                       sys_rst_n,
    input logic                       sw_rst,
    input logic                       bkp_por,
    input logic [ADDR_W_P-1:0]        bus_addr,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [DATA_W_P-1:0]        bus_rdata,
    input logic [NREG_P-1:0]          wmask,
    input logic [NREG_P-1:0]          rmask,
    input logic [NREG_P*DATA_W_P-1:0] store_flat
);
    logic             is_tgt;
    logic             is_mask;
    logic [IDX_W-1:0] aidx;
    logic             dom;

    assign is_tgt  = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) < NREG_P*4);
    assign is_mask = (bus_addr == 12'h800) || (bus_addr == 12'h804);
    assign aidx    = bus_addr[IDX_W+1:2];
    assign dom     = sw_rst || bkp_por;

    assert_mask_sticky_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ((wmask & ~$past(wmask)) == '0) && ((rmask & ~$past(rmask)) == '0));

    assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_wr && is_tgt && !wmask[aidx] && !dom)
        |=> $stable(store_flat));

    assert_blocked_read_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_rd && is_tgt && !rmask[aidx]) |=> (bus_rdata == '0));

    assert_mask_upper_zero_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_rd && is_mask) |=> (bus_rdata[DATA_W_P-1:NREG_P] == '0));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !bus_rd |=> (bus_rdata == '0));

    assert_soft_keeps_mask_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (dom && !bus_wr) |=> ($stable(wmask) && $stable(rmask)));

    assert_soft_clears_store_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        dom |=> (store_flat == '0));
endmodule

bind regaccess_guard regaccess_guard_checker #(
    .DATA_W_P (DATA_W_P),
    .ADDR_W_P (ADDR_W_P),
    .NREG_P   (NREG_P)
) u_chk (
    .clk        (clk),
    .sys_rst_n  (sys_rst_n),
    .sw_rst     (sw_rst),
    .bkp_por    (bkp_por),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .wmask      (wmask),
    .rmask      (rmask),
    .store_flat (store_flat)
);

// File: tb/regaccess_guard_test.sv
`timescale 1ns/1ps
module regaccess_guard_test;
    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        bkp_por = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    regaccess_guard uut (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .sw_rst    (sw_rst),
        .bkp_por   (bkp_por),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] tval(int i, logic [31:0] base);
        return base + 32'(i) * 32'h0101_0101;
    endfunction

    task automatic compare(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
    endtask

    task automatic pulse_bkp();
        @(negedge clk); bkp_por = 1'b1;
        @(negedge clk); bkp_por = 1'b0;
    endtask

    task automatic pulse_sys();
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
    endtask

    // Monitor: pops one expected item per read taken on an edge
    always @(posedge clk) begin
        logic fired;
        fired = bus_rd && sys_rst_n;
        #5;
        if (fired) begin
            if (exp_q.size() == 0) begin
                compare("scoreboard underflow", bus_rdata, 32'hxxxx_xxxx);
            end else begin
                compare(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        sys_rst_n = 1'b1;

        // R1 reset state
        bus_read(12'h800, 32'h0000_00FF, "R1 write mask reset");
        bus_read(12'h804, 32'h0000_00FF, "R1 read mask reset");
        bus_read(12'h000, 32'h0, "R1 target0 reset");

        // R3 store and read back all eight targets
        for (int i = 0; i < 8; i++) bus_write(12'(4*i), tval(i, 32'h1000_0000));
        for (int i = 0; i < 8; i++) bus_read(12'(4*i), tval(i, 32'h1000_0000), "R3 readback");

        // R2 reserved bits
        bus_write(12'h800, 32'hFFFF_FFFF);
        bus_read(12'h800, 32'h0000_00FF, "R2 write mask upper bits");
        bus_write(12'h804, 32'hFFFF_FF00 | 32'hFF);
        bus_read(12'h804, 32'h0000_00FF, "R2 read mask upper bits");

        // R6 clear seconds write bit; R4 blocked write
        bus_write(12'h800, 32'h0000_00FE);
        bus_read(12'h800, 32'h0000_00FE, "R6 write bit0 cleared");
        bus_write(12'h000, 32'hDEAD_BEEF);
        bus_read(12'h000, tval(0, 32'h1000_0000), "R4 blocked write keeps value");
        bus_write(12'h800, 32'h0000_00FF);
        bus_read(12'h800, 32'h0000_00FE, "R6 writing 1 does not re-arm");
        bus_write(12'h004, 32'h2222_3333);
        bus_read(12'h004, 32'h2222_3333, "R3 permitted neighbour write");

        // R5 clear interrupt enable read bit
        bus_write(12'h804, 32'h0000_007F);
        bus_read(12'h01C, 32'h0, "R5 blocked read returns zero");
        bus_read(12'h018, tval(6, 32'h1000_0000), "R5 permitted neighbour read");
        bus_read(12'h804, 32'h0000_007F, "R10 read mask readable");

        // R9 unmapped and idle
        bus_read(12'h020, 32'h0, "R9 unmapped read");
        bus_write(12'h400, 32'h5555_5555);
        bus_read(12'h800, 32'h0000_00FE, "R9 unmapped write leaves write mask");
        bus_read(12'h008, tval(2, 32'h1000_0000), "R9 unmapped write leaves target");
        @(negedge clk); @(negedge clk);
        compare("R9 idle rdata zero", bus_rdata, 32'h0);

        // R7 software and backup-domain resets
        pulse_sw();
        bus_read(12'h800, 32'h0000_00FE, "R7 sw reset keeps write mask");
        bus_read(12'h804, 32'h0000_007F, "R7 sw reset keeps read mask");
        bus_read(12'h004, 32'h0, "R7 sw reset clears target");
        bus_write(12'h008, 32'h7777_0000);
        pulse_bkp();
        bus_read(12'h800, 32'h0000_00FE, "R7 backup reset keeps write mask");
        bus_read(12'h804, 32'h0000_007F, "R7 backup reset keeps read mask");
        bus_read(12'h008, 32'h0, "R7 backup reset clears target");

        // R10 with masks fully cleared
        bus_write(12'h800, 32'h0);
        bus_write(12'h804, 32'h0);
        bus_read(12'h800, 32'h0, "R10 write mask readable when clear");
        bus_read(12'h804, 32'h0, "R10 read mask readable when clear");
        bus_write(12'h00C, 32'h1234_5678);

        // R8 system reset restores masks
        pulse_sys();
        bus_read(12'h800, 32'h0000_00FF, "R8 write mask restored");
        bus_read(12'h804, 32'h0000_00FF, "R8 read mask restored");
        bus_write(12'h000, 32'hCAFE_F00D);
        bus_read(12'h000, 32'hCAFE_F00D, "R8 seconds write restored");
        bus_write(12'h01C, 32'h0BAD_CAFE);
        bus_read(12'h01C, 32'h0BAD_CAFE, "R8 interrupt enable read restored");

        repeat (3) @(negedge clk);
        compare("scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule